// File: doc/BRIEF.md
# Auto-Increment Word-Program Sequencer

This block runs the auto-increment word-programming mode of a serial flash slave. A serial front end has already turned the incoming bit stream into single-cycle events: an opcode strobe, a strobe with the assembled 24-bit address, one strobe per data byte, and a strobe when chip select rises. The sequencer checks each event against the mode rules. It decides whether a two-byte word is written, and it issues the two byte write requests to the memory array model. It runs a busy timer for each word and keeps the mode's status bit.

The first programming command carries an address and two bytes. Each later command carries only two bytes, and these go to the next word. The mode ends when the host sends write disable, or by itself once the last unprotected byte has been written. The address never wraps. A separate option lets the serial output pin act as a ready/busy flag while chip select is low during the mode.

Top module: `aai_word_seq`

## Requirements
- R1: With `wel` high and the mode inactive, the sequence opcode 0xAD, address A, bytes D0 and D1, then a chip-select rise writes D0 to A with bit 0 cleared and D1 to A with bit 0 set. The writes appear as two consecutive `mem_we` cycles, even byte first. After this, `aai_active` is 1.
- R2: The entry command is dropped when `wel` is low, or when `prot_en` is 1 and the start address is at or above `prot_lo`. No byte is written and `aai_active` stays 0.
- R3: While the mode is active, a 0xAD command with two bytes and no address writes to the word that follows the previous word (word address + 2).
- R4: A word write starts only on the chip-select rise that ends a command. A command that ends with fewer than two data bytes writes nothing.
- R5: `busy` rises in the cycle after the chip-select rise that starts a word. It stays high for exactly BUSY_CYC cycles.
- R6: A 0xAD command received while `busy` is high is dropped. It writes nothing and does not advance the word pointer.
- R7: While the mode is active, every opcode other than 0xAD, 0x05 and 0x04 is ignored. This includes 0x70 and 0x80, so the ready/busy setting does not change.
- R8: Opcode 0x04 during the mode clears `aai_active` and pulses `wel_clr` for one cycle. A word write already running keeps `busy` high until its timer expires.
- R9: When a word ends at the highest unprotected address (`prot_lo`-1 with `prot_en`, otherwise all ones), `aai_active` clears and `wel_clr` pulses at that chip-select rise. The pointer does not wrap, and a further 0xAD writes nothing.
- R10: After opcode 0x70 (mode inactive), `rb_oe` is 1 whenever the mode is active and `cs_n` is low. During that time `rb_level` is 0 while busy and 1 when ready. `rb_oe` is 0 whenever `cs_n` is high.
- R11: Opcode 0x80 (mode inactive) turns the ready/busy output off, so `rb_oe` stays 0.
- R12: After reset, `aai_active`, `busy`, `wel_clr`, `mem_we` and `rb_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_stb | input | 1 | Opcode event strobe |
| op_code | input | 8 | Opcode value |
| addr_stb | input | 1 | Address event strobe |
| addr_in | input | AW | Assembled byte address |
| byte_stb | input | 1 | Data byte event strobe |
| byte_in | input | 8 | Data byte value |
| cs_rise | input | 1 | Chip-select rising-edge event |
| cs_n | input | 1 | Chip-select level (low = selected) |
| wel | input | 1 | Write-enable latch state |
| prot_en | input | 1 | Protection of the top region is on |
| prot_lo | input | AW | Lowest protected address |
| aai_active | output | 1 | Mode status bit |
| busy | output | 1 | Word write in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | AW | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| rb_oe | output | 1 | Serial output driven as ready/busy |
| rb_level | output | 1 | Ready/busy level (1 = ready) |

## Verification
Assertions check four ordering rules on every cycle. A write pair never starts without a preceding chip-select rise. The odd byte follows the even byte of the same word. The busy timer starts only on a chip-select rise. No write ever lands in the protected region. Leaving the mode is also tied to the latch-clear pulse. The bench scenarios have to show the rest: the address sequence across many words, dropped commands leaving the pointer alone, opcodes ignored during the mode, the stop at the top unprotected address without wrap-around, and the ready/busy pin level through a whole busy window.

// File: rtl/aai_word_seq.sv
module aai_word_seq #(
  parameter int AW       = 24,
  parameter int BUSY_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_stb,
  input  logic [7:0]    op_code,
  input  logic          addr_stb,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_stb,
  input  logic [7:0]    byte_in,
  input  logic          cs_rise,
  input  logic          cs_n,
  input  logic          wel,
  input  logic          prot_en,
  input  logic [AW-1:0] prot_lo,
  output logic          aai_active,
  output logic          busy,
  output logic          wel_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          rb_oe,
  output logic          rb_level
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [7:0] OP_WORD = 8'hAD;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RBON = 8'h70;
  localparam logic [7:0] OP_RBOFF = 8'h80;

  typedef enum logic [1:0] {C_IDLE, C_FIRST, C_NEXT, C_DROP} cmd_t;

  cmd_t          cmd;
  logic          addr_ok;
  logic [1:0]    nbytes;
  logic [7:0]    d0, d1, d1_q;
  logic [AW-1:0] ptr;
  logic          rb_mode;
  logic          sec_pend;
  logic [CW-1:0] cnt;

  logic [AW-1:0] top_addr;
  logic          start_prot, go, last_word, take_byte;

  assign busy       = (cnt != '0);
  assign top_addr   = prot_en ? (prot_lo - 1'b1) : '1;
  assign start_prot = prot_en && (addr_in >= prot_lo);
  assign take_byte  = byte_stb && (nbytes != 2'd2) &&
                      ((cmd == C_FIRST && addr_ok) || cmd == C_NEXT);
  assign go         = (nbytes == 2'd2) && ((cmd == C_FIRST && addr_ok) || cmd == C_NEXT);
  assign last_word  = ({ptr[AW-1:1], 1'b1} >= top_addr);
  assign rb_oe      = rb_mode && aai_active && !cs_n;
  assign rb_level   = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd        <= C_IDLE;
      addr_ok    <= 1'b0;
      nbytes     <= '0;
      d0         <= '0;
      d1         <= '0;
      d1_q       <= '0;
      ptr        <= '0;
      aai_active <= 1'b0;
      rb_mode    <= 1'b0;
      sec_pend   <= 1'b0;
      cnt        <= '0;
      wel_clr    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      wel_clr <= 1'b0;
      mem_we  <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;

      if (sec_pend) begin
        mem_we    <= 1'b1;
        mem_addr  <= {mem_addr[AW-1:1], 1'b1};
        mem_wdata <= d1_q;
        sec_pend  <= 1'b0;
      end

      if (op_stb) begin
        nbytes  <= '0;
        addr_ok <= 1'b0;
        cmd     <= C_IDLE;
        if (!aai_active) begin
          case (op_code)
            OP_WORD:  cmd <= (wel && !busy) ? C_FIRST : C_DROP;
            OP_RBON:  rb_mode <= 1'b1;
            OP_RBOFF: rb_mode <= 1'b0;
            default:  ;
          endcase
        end else begin
          case (op_code)
            OP_WORD: cmd <= busy ? C_DROP : C_NEXT;
            OP_WRDI: begin
              aai_active <= 1'b0;
              wel_clr    <= 1'b1;
            end
            default: ;
          endcase
        end
      end

      if (addr_stb && cmd == C_FIRST && !addr_ok) begin
        if (start_prot) cmd <= C_DROP;
        else begin
          ptr     <= {addr_in[AW-1:1], 1'b0};
          addr_ok <= 1'b1;
        end
      end

      if (take_byte) begin
        if (nbytes == 2'd0) d0 <= byte_in;
        else                d1 <= byte_in;
        nbytes <= nbytes + 2'd1;
      end

      if (cs_rise) begin
        cmd     <= C_IDLE;
        nbytes  <= '0;
        addr_ok <= 1'b0;
        if (go) begin
          mem_we     <= 1'b1;
          mem_addr   <= ptr;
          mem_wdata  <= d0;
          d1_q       <= d1;
          sec_pend   <= 1'b1;
          cnt        <= CW'(BUSY_CYC);
          ptr        <= ptr + AW'(2);
          aai_active <= !last_word;
          if (last_word) wel_clr <= 1'b1;
        end
      end
    end
  end

  assert_write_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> $past(cs_rise));

  assert_word_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[0] && mem_addr[AW-1:1] == $past(mem_addr[AW-1:1])));

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> !(mem_we && !$past(mem_we)));

  assert_exit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai_active) |-> wel_clr);

  assert_no_prot_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(prot_en && mem_addr >= prot_lo));
endmodule

// File: tb/aai_word_seq_tb.sv
module aai_word_seq_tb;
  localparam int AW = 24;
  localparam int BC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_stb = 0, addr_stb = 0, byte_stb = 0, cs_rise = 0, cs_n = 1;
  logic wel = 0, prot_en = 1;
  logic [7:0] op_code = 0, byte_in = 0;
  logic [AW-1:0] addr_in = 0, prot_lo = 24'h000100;
  logic aai_active, busy, wel_clr, mem_we, rb_oe, rb_level;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int ntest = 0, nfail = 0;
  int wcnt = 0, clrcnt = 0;
  logic [AW-1:0] wa [0:63];
  logic [7:0]    wd [0:63];

  always #2 clk = ~clk;

  aai_word_seq #(.AW(AW), .BUSY_CYC(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_code(op_code),
    .addr_stb(addr_stb), .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
    .cs_rise(cs_rise), .cs_n(cs_n), .wel(wel), .prot_en(prot_en), .prot_lo(prot_lo),
    .aai_active(aai_active), .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rb_oe(rb_oe), .rb_level(rb_level));

  always @(negedge clk) begin
    if (mem_we && wcnt < 64) begin
      wa[wcnt] <= mem_addr;
      wd[wcnt] <= mem_wdata;
    end
    if (mem_we) wcnt <= wcnt + 1;
    if (wel_clr) clrcnt <= clrcnt + 1;
  end

  function automatic logic [AW-1:0] exp_word(input logic [AW-1:0] start, input int k);
    return {start[AW-1:1], 1'b0} + AW'(2 * k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_ad(input bit first, input logic [AW-1:0] a, input int nb,
                         input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk); cs_n = 0; op_code = 8'hAD; op_stb = 1;
    @(negedge clk); op_stb = 0;
    if (first) begin addr_in = a; addr_stb = 1; @(negedge clk); addr_stb = 0; end
    if (nb > 0) begin byte_in = b0; byte_stb = 1; @(negedge clk); byte_stb = 0; end
    if (nb > 1) begin byte_in = b1; byte_stb = 1; @(negedge clk); byte_stb = 0; end
    cs_n = 1; cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic send_op(input logic [7:0] op);
    @(negedge clk); cs_n = 0; op_code = op; op_stb = 1;
    @(negedge clk); op_stb = 0; cs_n = 1; cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic wait_idle();
    repeat (BC + 2) @(negedge clk);
  endtask

  task automatic chk_word(input int base, input logic [AW-1:0] a, input logic [7:0] b0,
                          input logic [7:0] b1, input string req);
    chk(wcnt == base + 2, req, wcnt - base, 2);
    chk(wa[base] == a && wd[base] == b0, req, {wa[base], wd[base]}, {a, b0});
    chk(wa[base+1] == (a | 1) && wd[base+1] == b1, req, {wa[base+1], wd[base+1]}, {a | 24'd1, b1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int base, c0;
    logic [7:0] r0, r1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!aai_active && !busy && !wel_clr && !mem_we && !rb_oe, "R12", {aai_active, busy, wel_clr, mem_we, rb_oe}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 entry without write enable
    base = wcnt;
    send_ad(1, 24'h000010, 2, 8'h11, 8'h22); wait_idle();
    chk(wcnt == base && !aai_active, "R2 no wel", {wcnt - base, aai_active}, 0);
    // R2 protected start
    wel = 1;
    send_ad(1, 24'h000180, 2, 8'h11, 8'h22); wait_idle();
    chk(wcnt == base && !aai_active, "R2 protected", {wcnt - base, aai_active}, 0);

    // R10 enable ready/busy, R1 entry with odd address, R5 busy window
    send_op(8'h70);
    base = wcnt;
    send_ad(1, 24'h000021, 2, 8'hA5, 8'h3C);
    chk(busy == 1, "R5 rise", busy, 1);
    cs_n = 0; #1;
    chk(rb_oe && !rb_level, "R10 busy level", {rb_oe, rb_level}, 2'b10);
    repeat (BC - 1) @(negedge clk);
    chk(busy == 1, "R5 hold", busy, 1);
    @(negedge clk);
    chk(busy == 0, "R5 fall", busy, 0);
    chk(rb_oe && rb_level, "R10 ready level", {rb_oe, rb_level}, 2'b11);
    cs_n = 1; #1;
    chk(!rb_oe, "R10 cs high", rb_oe, 0);
    chk_word(base, 24'h000020, 8'hA5, 8'h3C, "R1");
    chk(aai_active, "R1 active", aai_active, 1);

    // R6 command during busy is dropped
    base = wcnt;
    send_ad(0, 0, 2, 8'h01, 8'h02);
    send_ad(0, 0, 2, 8'hEE, 8'hFF);
    wait_idle();
    chk(wcnt == base + 2, "R6 drop", wcnt - base, 2);
    chk_word(base, 24'h000022, 8'h01, 8'h02, "R3 next word");

    // R4 incomplete command
    base = wcnt;
    send_ad(0, 0, 1, 8'h55, 8'h00); wait_idle();
    chk(wcnt == base && !busy, "R4 one byte", wcnt - base, 0);

    // R7 illegal opcodes ignored while active
    send_op(8'h80); send_op(8'h06); send_op(8'h02); send_op(8'h20);
    chk(wcnt == base && aai_active, "R7 ignored", {wcnt - base, aai_active}, 1);
    base = wcnt;
    send_ad(0, 0, 2, 8'h77, 8'h88);
    cs_n = 0; #1;
    chk(rb_oe && !rb_level, "R7 80h ignored", {rb_oe, rb_level}, 2'b10);
    cs_n = 1; wait_idle();
    chk_word(base, 24'h000024, 8'h77, 8'h88, "R3 after ignored");

    // R3 random words with random stray opcodes
    for (int k = 0; k < 6; k++) begin
      r0 = 8'($urandom); r1 = 8'($urandom);
      base = wcnt;
      send_ad(0, 0, 2, r0, r1); wait_idle();
      chk_word(base, exp_word(24'h000026, k), r0, r1, "R3 random");
      c0 = wcnt;
      case ($urandom % 4)
        0: send_op(8'h06);
        1: send_op(8'h9F);
        2: send_op(8'h05);
        default: send_op(8'h03);
      endcase
      chk(wcnt == c0 && aai_active, "R7 random op", {wcnt - c0, aai_active}, 1);
    end

    // R8 write disable during a running write
    c0 = clrcnt;
    send_ad(0, 0, 2, 8'h12, 8'h34);
    send_op(8'h04);
    chk(!aai_active, "R8 exit", aai_active, 0);
    chk(busy == 1, "R8 write continues", busy, 1);
    chk(clrcnt == c0 + 1, "R8 wel_clr", clrcnt - c0, 1);
    wait_idle();
    wel = 0;

    // R11 ready/busy off, R9 top address exit
    send_op(8'h80);
    wel = 1;
    c0 = clrcnt;
    base = wcnt;
    send_ad(1, 24'h0000F8, 2, 8'hC0, 8'hC1);
    cs_n = 0; #1;
    chk(!rb_oe, "R11 off", rb_oe, 0);
    cs_n = 1; wait_idle();
    for (int k = 1; k < 4; k++) begin
      send_ad(0, 0, 2, 8'hC0 + 8'(2 * k), 8'hC1 + 8'(2 * k)); wait_idle();
    end
    chk(wcnt == base + 8, "R9 count", wcnt - base, 8);
    chk(wa[base+7] == 24'h0000FF, "R9 last addr", wa[base+7], 24'hFF);
    chk(!aai_active && clrcnt == c0 + 1, "R9 exit", {aai_active, 8'(clrcnt - c0)}, 9'h001);
    wel = 0;
    base = wcnt;
    send_ad(0, 0, 2, 8'h99, 8'h98); wait_idle();
    chk(wcnt == base && !aai_active, "R9 no wrap", wcnt - base, 0);

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule